// File: doc/BRIEF.md
# Indexed-Colour Display Layer

This block turns a stream of panel coordinates into 24-bit RGB pixels for a single display layer whose frame buffer holds one 8-bit index per pixel. For each coordinate inside the programmed window, it reads one byte from frame-buffer memory. That byte either selects an entry of a 256-entry colour table or, with the table switched off, becomes a grey level. The result appears on the output together with a delayed data-enable.

Any coordinate outside the window, below the last fetched line, or whose looked-up colour equals the transparency key shows a programmable background colour instead. The same happens at every coordinate while the layer is switched off.

Software programs the layer through an 8-entry write-only register port and must switch the layer off before it changes the window, base or geometry. Colour-table entries are written one at a time through a single packed register.

Top module: `idx_layer`

## Requirements
- R1: While reset is held and in the cycle after it, `out_de`, `out_rgb` and `mem_rd` are all zero.
- R2: `out_de` equals `pix_de` delayed by exactly two clocks, and `out_rgb` is zero whenever `out_de` is low.
- R3: A read is issued in the same cycle as a coordinate that is inside the window, within the line count and on an enabled layer. Its address is base (offset 5) + (y − vertical start) × pitch + (x − horizontal start). Pitch is bits 15:0 of offset 6.
- R4: Writing offset 7 stores bits 23:0 as the colour of table entry bits 31:24. With control bit 4 set, a fetched pixel shows the table entry selected by its byte.
- R5: With control bit 4 clear, a fetched byte v is shown as the grey colour {v, v, v}.
- R6: The window is inclusive on both edges. Offset 3 holds the horizontal edges as {end[31:16], start[15:0]} and offset 4 holds the vertical edges in the same layout. Coordinates outside the window show the background colour (offset 1, bits 23:0) and issue no read.
- R7: Lines whose distance from the vertical start is at or beyond the line count (offset 6, bits 31:16) show the background and issue no read, even when they are inside the window.
- R8: With control bit 1 set, a pixel whose looked-up colour equals the key (offset 2, bits 23:0) shows the background. With bit 1 clear, the same pixel shows its colour.
- R9: With control bit 0 (offset 0) clear, every enabled coordinate shows the background and no read is issued.
- R10: Writes to offsets 3 to 6 while control bit 0 is set are ignored.
- R11: A table write lands in the same cycle that a pixel with that index is being resolved. That pixel still shows the old colour, and the next pixel with that index shows the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_x | input | COORD_W | Horizontal panel coordinate, counted from the start of horizontal sync |
| pix_y | input | COORD_W | Vertical panel coordinate, counted from the start of vertical sync |
| pix_de | input | 1 | Active-area data enable for this coordinate |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register offset |
| cfg_wdata | input | 32 | Register write data |
| mem_rd | output | 1 | Frame-buffer read request |
| mem_addr | output | ADDR_W | Frame-buffer byte address |
| mem_rdata | input | 8 | Read data, valid one clock after the request |
| out_rgb | output | 24 | Output pixel colour, R in bits 23:16 |
| out_de | output | 1 | Output data enable |

## Verification
A colour-table write and the lookup of that same entry can fall in one cycle. To provoke this, the bench presents the same fetched coordinate twice in a row and drives the write for that pixel's index alongside the second coordinate. The first pixel must show the colour held before the write and the second must show the new colour, which pins the write-after-read order of the table. Keying, window edges and the line limit are judged pixel by pixel against an independent model of the register contents and memory.

// File: rtl/idx_layer_pkg.sv
package idx_layer_pkg;

    localparam int IDX_W  = 8;
    localparam int LUT_N  = 1 << IDX_W;
    localparam int RGB_W  = 24;

    typedef logic [RGB_W-1:0] rgb_t;

    typedef enum logic [2:0] {
        OFS_CTRL = 3'd0,
        OFS_BG   = 3'd1,
        OFS_KEY  = 3'd2,
        OFS_HWIN = 3'd3,
        OFS_VWIN = 3'd4,
        OFS_BASE = 3'd5,
        OFS_GEOM = 3'd6,
        OFS_LUT  = 3'd7
    } ofs_e;

    typedef struct packed {
        logic lut_on;
        logic key_on;
        logic layer_on;
    } ctrl_t;

    typedef struct packed {
        logic [15:0] h_start;
        logic [15:0] h_end;
        logic [15:0] v_start;
        logic [15:0] v_end;
        logic [15:0] pitch;
        logic [15:0] lines;
    } geom_t;

    typedef struct packed {
        logic de;
        logic hit;
    } stage_t;

    function automatic rgb_t grey_of(logic [IDX_W-1:0] v);
        return {v, v, v};
    endfunction

    function automatic logic is_geom_ofs(logic [2:0] a);
        return (a == OFS_HWIN) || (a == OFS_VWIN) || (a == OFS_BASE) || (a == OFS_GEOM);
    endfunction

endpackage

// File: rtl/idx_layer_regs.sv
module idx_layer_regs
    import idx_layer_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [2:0]        addr,
    input  logic [31:0]       wdata,
    output ctrl_t             ctrl,
    output rgb_t              bg,
    output rgb_t              key,
    output geom_t             geom,
    output logic [ADDR_W-1:0] base,
    output logic              lut_we,
    output logic [IDX_W-1:0]  lut_idx,
    output rgb_t              lut_rgb
);

    logic geom_open;
    assign geom_open = we && !ctrl.layer_on && is_geom_ofs(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            bg   <= '0;
            key  <= '0;
            geom <= '0;
            base <= '0;
        end else begin
            if (we && addr == OFS_CTRL) begin
                ctrl.layer_on <= wdata[0];
                ctrl.key_on   <= wdata[1];
                ctrl.lut_on   <= wdata[4];
            end
            if (we && addr == OFS_BG)  bg  <= wdata[RGB_W-1:0];
            if (we && addr == OFS_KEY) key <= wdata[RGB_W-1:0];
            if (geom_open) begin
                case (addr)
                    OFS_HWIN: begin
                        geom.h_start <= wdata[15:0];
                        geom.h_end   <= wdata[31:16];
                    end
                    OFS_VWIN: begin
                        geom.v_start <= wdata[15:0];
                        geom.v_end   <= wdata[31:16];
                    end
                    OFS_BASE: base <= wdata[ADDR_W-1:0];
                    OFS_GEOM: begin
                        geom.pitch <= wdata[15:0];
                        geom.lines <= wdata[31:16];
                    end
                    default: ;
                endcase
            end
        end
    end

    assign lut_we  = we && (addr == OFS_LUT);
    assign lut_idx = wdata[31:24];
    assign lut_rgb = wdata[RGB_W-1:0];

    // R10: geometry held while the layer runs
    assert_geom_locked_R10: assert property (@(posedge clk) disable iff (rst)
        (we && ctrl.layer_on && is_geom_ofs(addr)) |=> ($stable(geom) && $stable(base)));

endmodule

// File: rtl/idx_layer_fetch.sv
module idx_layer_fetch
    import idx_layer_pkg::*;
#(
    parameter int COORD_W = 12,
    parameter int ADDR_W  = 20
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [COORD_W-1:0] pix_x,
    input  logic [COORD_W-1:0] pix_y,
    input  logic               pix_de,
    input  ctrl_t              ctrl,
    input  geom_t              geom,
    input  logic [ADDR_W-1:0]  base,
    output logic               mem_rd,
    output logic [ADDR_W-1:0]  mem_addr,
    output stage_t             st
);

    logic [15:0] x16, y16, col, line;
    logic        in_h, in_v, in_l;

    always_comb begin
        x16  = 16'(pix_x);
        y16  = 16'(pix_y);
        col  = x16 - geom.h_start;
        line = y16 - geom.v_start;
        in_h = (x16 >= geom.h_start) && (x16 <= geom.h_end);
        in_v = (y16 >= geom.v_start) && (y16 <= geom.v_end);
        in_l = line < geom.lines;
    end

    assign mem_rd   = ctrl.layer_on && pix_de && in_h && in_v && in_l;
    assign mem_addr = base + ADDR_W'(32'(line) * 32'(geom.pitch)) + ADDR_W'(col);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            st.de  <= pix_de;
            st.hit <= mem_rd;
        end
    end

    // R9: an idle layer never touches memory
    assert_no_read_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !ctrl.layer_on |-> !mem_rd);

    // R3: reads only on active coordinates
    assert_read_on_de_R3: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> pix_de);

endmodule

// File: rtl/idx_layer_color.sv
module idx_layer_color
    import idx_layer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  stage_t           st,
    input  logic [IDX_W-1:0] rdata,
    input  ctrl_t            ctrl,
    input  rgb_t             bg,
    input  rgb_t             key,
    input  logic             lut_we,
    input  logic [IDX_W-1:0] lut_idx,
    input  rgb_t             lut_rgb,
    output rgb_t             out_rgb,
    output logic             out_de
);

    rgb_t lut [LUT_N];
    rgb_t looked;
    logic keyed;
    rgb_t nxt;

    always_ff @(posedge clk) begin
        if (lut_we) lut[lut_idx] <= lut_rgb;
    end

    always_comb begin
        looked = ctrl.lut_on ? lut[rdata] : grey_of(rdata);
        keyed  = ctrl.key_on && (looked == key);
        if (!st.de)                nxt = '0;
        else if (st.hit && !keyed) nxt = looked;
        else                       nxt = bg;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_rgb <= '0;
            out_de  <= 1'b0;
        end else begin
            out_rgb <= nxt;
            out_de  <= st.de;
        end
    end

    // R8: a keyed pixel resolves to the background
    assert_key_shows_bg_R8: assert property (@(posedge clk) disable iff (rst)
        (st.de && st.hit && ctrl.key_on && looked == key) |=> (out_rgb == $past(bg)));

endmodule

// File: rtl/idx_layer.sv
module idx_layer
    import idx_layer_pkg::*;
#(
    parameter int COORD_W = 12,
    parameter int ADDR_W  = 20
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [COORD_W-1:0] pix_x,
    input  logic [COORD_W-1:0] pix_y,
    input  logic               pix_de,
    input  logic               cfg_we,
    input  logic [2:0]         cfg_addr,
    input  logic [31:0]        cfg_wdata,
    output logic               mem_rd,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic [7:0]         mem_rdata,
    output logic [23:0]        out_rgb,
    output logic               out_de
);

    ctrl_t             ctrl;
    rgb_t              bg, key, lut_rgb;
    geom_t             geom;
    logic [ADDR_W-1:0] base;
    logic              lut_we;
    logic [IDX_W-1:0]  lut_idx;
    stage_t            st;

    idx_layer_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .ctrl(ctrl), .bg(bg), .key(key), .geom(geom), .base(base),
        .lut_we(lut_we), .lut_idx(lut_idx), .lut_rgb(lut_rgb)
    );

    idx_layer_fetch #(.COORD_W(COORD_W), .ADDR_W(ADDR_W)) u_fetch (
        .clk(clk), .rst(rst), .pix_x(pix_x), .pix_y(pix_y), .pix_de(pix_de),
        .ctrl(ctrl), .geom(geom), .base(base),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .st(st)
    );

    idx_layer_color u_color (
        .clk(clk), .rst(rst), .st(st), .rdata(mem_rdata), .ctrl(ctrl),
        .bg(bg), .key(key), .lut_we(lut_we), .lut_idx(lut_idx), .lut_rgb(lut_rgb),
        .out_rgb(out_rgb), .out_de(out_de)
    );

    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                  since_rst <= '0;
        else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
    end

    // R2: two-clock alignment of the data enable
    assert_de_latency_R2: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd2) |-> (out_de == $past(pix_de, 2)));

    // R2: blanked colour outside the active area
    assert_blank_zero_R2: assert property (@(posedge clk) disable iff (rst)
        !out_de |-> (out_rgb == '0));

endmodule

// File: tb/idx_layer_tb.sv
module idx_layer_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [11:0] pix_x, pix_y;
    logic        pix_de;
    logic        cfg_we;
    logic [2:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic        mem_rd;
    logic [19:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic [23:0] out_rgb;
    logic        out_de;

    always #2.5 clk = ~clk;

    idx_layer u_dut (
        .clk(clk), .rst(rst), .pix_x(pix_x), .pix_y(pix_y), .pix_de(pix_de),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .out_rgb(out_rgb), .out_de(out_de)
    );

    logic [7:0] bmem [4096];
    always @(posedge clk) if (mem_rd) mem_rdata <= bmem[mem_addr[11:0]];

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // model of programmed state
    logic [31:0] m_ctrl;
    logic [23:0] m_bg, m_key;
    int          m_hs, m_he, m_vs, m_ve, m_base, m_pitch, m_lines;
    logic [23:0] m_lut [256];

    // two-deep expectation pipe
    logic [23:0] e_rgb [2];
    logic        e_de  [2];
    logic        e_v   [2];
    string       e_tag [2];

    function automatic logic [23:0] lv(int i);
        return {8'(i), 8'(255 - i), 8'(i) ^ 8'h5A};
    endfunction

    function automatic bit m_hit(int x, int y, bit de);
        return m_ctrl[0] && de && x >= m_hs && x <= m_he && y >= m_vs && y <= m_ve
               && (y - m_vs) < m_lines;
    endfunction

    function automatic int m_addr(int x, int y);
        return m_base + (y - m_vs) * m_pitch + (x - m_hs);
    endfunction

    function automatic logic [23:0] m_rgb(int x, int y, bit de);
        logic [7:0]  v;
        logic [23:0] c;
        if (!de) return 24'h0;
        if (!m_hit(x, y, de)) return m_bg;
        v = bmem[m_addr(x, y) & 4095];
        c = m_ctrl[4] ? m_lut[v] : {v, v, v};
        if (m_ctrl[1] && c == m_key) return m_bg;
        return c;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic step(int x, int y, bit de, bit we, int adr, logic [31:0] d, string tag);
        @(negedge clk);
        if (e_v[1]) begin
            check("R2", {31'b0, out_de}, {31'b0, e_de[1]});
            check(e_tag[1], {8'b0, out_rgb}, {8'b0, e_rgb[1]});
        end
        e_v[1] = e_v[0]; e_de[1] = e_de[0]; e_rgb[1] = e_rgb[0]; e_tag[1] = e_tag[0];
        cfg_we = we; cfg_addr = 3'(adr); cfg_wdata = d;
        if (we) begin
            case (adr)
                0: m_ctrl = d;
                1: m_bg = d[23:0];
                2: m_key = d[23:0];
                3: if (!m_ctrl[0]) begin m_hs = int'(d[15:0]); m_he = int'(d[31:16]); end
                4: if (!m_ctrl[0]) begin m_vs = int'(d[15:0]); m_ve = int'(d[31:16]); end
                5: if (!m_ctrl[0]) m_base = int'(d[19:0]);
                6: if (!m_ctrl[0]) begin m_pitch = int'(d[15:0]); m_lines = int'(d[31:16]); end
                7: m_lut[d[31:24]] = d[23:0];
                default: ;
            endcase
        end
        pix_x = 12'(x); pix_y = 12'(y); pix_de = de;
        e_v[0] = 1'b1; e_de[0] = de; e_rgb[0] = m_rgb(x, y, de); e_tag[0] = tag;
        #1;
        check(tag, {31'b0, mem_rd}, {31'b0, m_hit(x, y, de)});
        if (m_hit(x, y, de)) check(tag, {12'b0, mem_addr}, 32'(m_addr(x, y)));
    endtask

    task automatic wr(int adr, logic [31:0] d, string tag);
        step(0, 0, 1'b0, 1'b1, adr, d, tag);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, 1'b0, 1'b0, 0, 32'h0, "R2");
    endtask

    task automatic scan(string tag);
        for (int y = 2; y <= 7; y++)
            for (int x = 0; x <= 16; x++)
                step(x, y, x < 16, 1'b0, 0, 32'h0, tag);
        idle(2);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", {30'b0, out_de, mem_rd}, 32'h0);
        check("R1", {8'b0, out_rgb}, 32'h0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", {30'b0, out_de, mem_rd}, 32'h0);
        check("R1", {8'b0, out_rgb}, 32'h0);
    endtask

    task automatic t_window_lut();
        for (int i = 0; i < 256; i++) wr(7, {8'(i), lv(i)}, "R4");
        wr(1, 32'h00FF00FF, "R6");
        wr(3, {16'd12, 16'd5}, "R6");
        wr(4, {16'd6, 16'd3}, "R6");
        wr(5, 32'd100, "R3");
        wr(6, {16'd3, 16'd20}, "R7");
        wr(0, 32'h11, "R4");
        scan("R4_R3_R6_R7");
    endtask

    task automatic t_grey();
        wr(0, 32'h01, "R5");
        scan("R5");
    endtask

    task automatic t_key();
        logic [23:0] kc;
        kc = lv(int'(bmem[100 + 20 + 2]));
        wr(2, {8'h0, kc}, "R8");
        wr(0, 32'h13, "R8");
        scan("R8_on");
        wr(0, 32'h11, "R8");
        scan("R8_off");
    endtask

    task automatic t_disabled();
        wr(0, 32'h10, "R9");
        wr(1, 32'h00123456, "R9");
        scan("R9");
    endtask

    task automatic t_ignore();
        wr(0, 32'h11, "R10");
        wr(3, {16'd9, 16'd2}, "R10");
        wr(4, {16'd7, 16'd2}, "R10");
        wr(5, 32'd300, "R10");
        wr(6, {16'd9, 16'd7}, "R10");
        scan("R10");
    endtask

    task automatic t_collision();
        logic [7:0] v;
        v = bmem[m_addr(5, 3) & 4095];
        step(5, 3, 1'b1, 1'b0, 0, 32'h0, "R11_old");
        step(5, 3, 1'b1, 1'b1, 7, {v, 24'hC0FFEE}, "R11_new");
        step(5, 3, 1'b1, 1'b0, 0, 32'h0, "R11_new");
        idle(3);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        for (int a = 0; a < 4096; a++) bmem[a] = 8'((a * 37 + 11) & 255);
        e_v[0] = 1'b0; e_v[1] = 1'b0;
        e_de[0] = 1'b0; e_de[1] = 1'b0;
        e_rgb[0] = '0; e_rgb[1] = '0;
        e_tag[0] = ""; e_tag[1] = "";
        m_ctrl = '0; m_bg = '0; m_key = '0;
        m_hs = 0; m_he = 0; m_vs = 0; m_ve = 0; m_base = 0; m_pitch = 0; m_lines = 0;
        pix_x = '0; pix_y = '0; pix_de = 1'b0;
        cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        t_reset();
        t_window_lut();
        t_grey();
        t_key();
        t_disabled();
        t_ignore();
        t_collision();
        report();
    end

endmodule